// File: doc/BRIEF.md
# Self-Timed Byte Write Sequencer for a Nonvolatile Word Array

This block sits behind a two-wire serial memory front end. Once the front end has seen a complete write transaction, it hands over one byte and its word address. From then on the sequencer runs the whole nonvolatile update by itself. The target word is first cleared to the erased pattern (all ones) and then loaded with the new data. There is no separate erase command. An internal cycle counter times both steps. The length of the whole update is the parameter `TWR_CYCLES`, given in system clock cycles. Elaboration rejects any setting longer than 5 ms at the stated clock frequency. The erase step takes the first half of the count, rounded down, and the program step takes the rest.

A busy flag stays high for every cycle of the update. The front end uses this flag to withhold acknowledges and to ignore all bus traffic. Any further commit that arrives during the update is dropped. When the update ends, busy falls and a single-cycle done pulse follows. The array holds 128 words of 8 bits as registers. It has an independent read port. A synchronous reset cancels an update that is in progress and leaves the stored words as they are.

Top module: `nvw_seq`

## Requirements
- R1: When busy is low and `commit_req` is high at a rising clock edge, the request is accepted and `busy` reads 1 in the following cycle.
- R2: After acceptance, `busy` stays high for exactly `TWR_CYCLES` consecutive clock cycles and then falls without any outside action.
- R3: From the cycle after acceptance until busy falls, the target word reads 8'hFF on the read port, whatever it held before.
- R4: When the update completes, the target word holds the committed byte, and no other word has changed.
- R5: A `commit_req` that arrives while busy is high has no effect. The timer is not restarted, busy falls at the originally scheduled edge, and the address named in the ignored request keeps its old contents.
- R6: `done` is high for exactly one cycle: the cycle that directly follows the first cycle in which `busy` is low again.
- R7: The new data appears on the read port in the same cycle in which `busy` first reads 0. In the last busy cycle, the target word still reads 8'hFF.
- R8: Synchronous reset (`rst` = 1) forces `busy` and `done` to 0 and abandons the update in progress. Array contents stay exactly as they were: a word that was already erased stays 8'hFF, and every other word keeps its value. No done pulse follows an abandoned update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| commit_req | input | 1 | Request to start a byte update, sampled at each edge |
| commit_addr | input | ADDR_W | Word address of the update |
| commit_data | input | DATA_W | Byte to be stored |
| rd_addr | input | ADDR_W | Read port word address |
| rd_data | output | DATA_W | Read port data (combinational when READ_REG = 0) |
| busy | output | 1 | High while an update is in progress |
| done | output | 1 | One-cycle pulse one cycle after busy falls |

## Verification
The bench builds the block with `TWR_CYCLES` = 7 and the default 7-bit address and 8-bit data. With this short cycle, all 128 words can each go through a complete erase-then-program update in a few thousand clocks, and the bench counts and checks every busy cycle of every update. Because 7 is odd, the erase step (3 cycles) and the program step (4 cycles) have different lengths, which tests the split of the count into two phases. The combinational read port lets the bench observe the erased value and the freshly written value in the exact cycle each one should appear.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ERASE = 2'd1,
      PH_PROG  = 2'd2
   } nvw_phase_e;

   // erase step length: first half of the total, rounded down
   function automatic int erase_len(input int total);
      return total / 2;
   endfunction

endpackage

// File: rtl/nvw_cycle_timer.sv
module nvw_cycle_timer #(
   parameter int TWR_CYCLES = 625000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic run,
   output logic erase_end,
   output logic cycle_end
);
   localparam int CNT_W   = (TWR_CYCLES > 2) ? $clog2(TWR_CYCLES) : 1;
   localparam int ERASE_N = nvw_pkg::erase_len(TWR_CYCLES);
   localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_N - 1);
   localparam logic [CNT_W-1:0] CYCLE_LAST = CNT_W'(TWR_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign erase_end = run && (cnt_q == ERASE_LAST);
   assign cycle_end = run && (cnt_q == CYCLE_LAST);

endmodule

// File: rtl/nvw_seq_ctrl.sv
module nvw_seq_ctrl #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit_req,
   input  logic [ADDR_W-1:0] commit_addr,
   input  logic [DATA_W-1:0] commit_data,
   input  logic              erase_end,
   input  logic              cycle_end,
   output logic              start,
   output logic              busy,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);
   import nvw_pkg::*;

   localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

   nvw_phase_e        phase_q, phase_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              finish;
   logic              fin_q;
   logic              done_q;

   assign busy   = (phase_q != PH_IDLE);
   assign start  = !rst && (phase_q == PH_IDLE) && commit_req;
   assign finish = !rst && (phase_q == PH_PROG) && cycle_end;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (commit_req) phase_d = PH_ERASE;
         PH_ERASE: if (erase_end)  phase_d = PH_PROG;
         PH_PROG:  if (cycle_end)  phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         fin_q   <= finish;
         done_q  <= fin_q;
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         addr_q <= commit_addr;
         data_q <= commit_data;
      end
   end

   // erase is applied at acceptance, program at the final edge
   always_comb begin
      wr_en   = start || finish;
      wr_addr = start ? commit_addr : addr_q;
      wr_data = start ? ERASED : data_q;
   end

   assign done = done_q;

endmodule

// File: rtl/nvw_word_array.sv
module nvw_word_array #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int READ_REG = 0
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   generate
      if (READ_REG != 0) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            rd_q <= mem_q[rd_addr];
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = mem_q[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/nvw_seq.sv
module nvw_seq #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int CLK_KHZ    = 125000,
   parameter int TWR_CYCLES = 625000,
   parameter int READ_REG   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit_req,
   input  logic [ADDR_W-1:0] commit_addr,
   input  logic [DATA_W-1:0] commit_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done
);
   localparam int MAX_CYCLES = 5 * CLK_KHZ;

   generate
      if (TWR_CYCLES < 2) begin : g_err_short
         $error("nvw_seq: TWR_CYCLES must be at least 2");
      end
      if (TWR_CYCLES > MAX_CYCLES) begin : g_err_long
         $error("nvw_seq: TWR_CYCLES exceeds 5 ms at CLK_KHZ");
      end
      if (READ_REG < 0 || READ_REG > 1) begin : g_err_rd
         $error("nvw_seq: READ_REG must be 0 or 1");
      end
      if (ADDR_W < 1 || ADDR_W > 12 || DATA_W < 1) begin : g_err_geom
         $error("nvw_seq: array geometry out of range");
      end
   endgenerate

   logic              start;
   logic              erase_end;
   logic              cycle_end;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   nvw_cycle_timer #(
      .TWR_CYCLES(TWR_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .run      (busy),
      .erase_end(erase_end),
      .cycle_end(cycle_end)
   );

   nvw_seq_ctrl #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .commit_req (commit_req),
      .commit_addr(commit_addr),
      .commit_data(commit_data),
      .erase_end  (erase_end),
      .cycle_end  (cycle_end),
      .start      (start),
      .busy       (busy),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .done       (done)
   );

   nvw_word_array #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .READ_REG(READ_REG)
   ) u_array (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

endmodule

// File: rtl/nvw_seq_chk.sv
module nvw_seq_chk #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int TWR_CYCLES = 625000,
   parameter int READ_REG   = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              commit_req,
   input logic [ADDR_W-1:0] commit_addr,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              done
);
   localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

   logic [31:0]       busy_run_q;
   logic [ADDR_W-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (rst || !busy) busy_run_q <= '0;
      else              busy_run_q <= busy_run_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst && !busy && commit_req) tgt_q <= commit_addr;
   end

   // R1
   accept_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && commit_req) |=> busy);

   // R2
   hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && busy_run_q < 32'(TWR_CYCLES - 1)) |=> busy);

   // R2
   cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> (busy_run_q == 32'(TWR_CYCLES)));

   // R3
   erased_read_chk: assert property (@(posedge clk) disable iff (rst)
      ((READ_REG == 0) && busy && rd_addr == tgt_q) |-> (rd_data == ERASED));

   // R6
   done_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |=> done);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!busy && !done));

endmodule

bind nvw_seq nvw_seq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .TWR_CYCLES(TWR_CYCLES),
   .READ_REG  (READ_REG)
) u_nvw_seq_chk (
   .clk        (clk),
   .rst        (rst),
   .commit_req (commit_req),
   .commit_addr(commit_addr),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .busy       (busy),
   .done       (done)
);

// File: tb/nvw_seq_bench.sv
module nvw_seq_bench;
   localparam int TWR = 7;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       commit_req = 1'b0;
   logic [6:0] commit_addr = '0;
   logic [7:0] commit_data = '0;
   logic [6:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       busy;
   logic       done;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;
   logic [7:0] model [128];

   always #4 clk = ~clk;

   nvw_seq #(
      .ADDR_W(7), .DATA_W(8), .CLK_KHZ(125000), .TWR_CYCLES(TWR), .READ_REG(0)
   ) u_nvw_seq (
      .clk(clk), .rst(rst), .commit_req(commit_req), .commit_addr(commit_addr),
      .commit_data(commit_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 29 + 3) ^ (a >> 2));
   endfunction

   task automatic read_word(input int a, output logic [7:0] v);
      rd_addr = 7'(a);
      #1;
      v = rd_data;
   endtask

   // drive one commit; returns at the negedge after the accepting edge
   task automatic commit(input int a, input logic [7:0] d);
      @(negedge clk);
      commit_req  = 1'b1;
      commit_addr = 7'(a);
      commit_data = d;
      @(negedge clk);
      commit_req  = 1'b0;
   endtask

   task automatic full_write(input int a, input logic [7:0] d);
      int n;
      logic [7:0] v;
      commit(a, d);
      check(busy === 1'b1, "R1", "busy after accept", int'(busy), 1);
      read_word(a, v);
      check(v === 8'hFF, "R3", "erased word first cycle", int'(v), 8'hFF);
      n = 1;
      forever begin
         @(negedge clk);
         if (busy !== 1'b1) break;
         n++;
         check(rd_data === 8'hFF, "R3", "erased word mid cycle", int'(rd_data), 8'hFF);
         check(done === 1'b0, "R6", "no done while busy", int'(done), 0);
         if (n > TWR + 2) break;
      end
      check(n == TWR, "R2", "busy length", n, TWR);
      check(rd_data === d, "R7", "data at busy fall", int'(rd_data), int'(d));
      check(done === 1'b0, "R6", "done not with fall", int'(done), 0);
      model[a] = d;
      @(negedge clk);
      check(done === 1'b1, "R6", "done pulse", int'(done), 1);
      @(negedge clk);
      check(done === 1'b0, "R6", "done width", int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      check(busy === 1'b0, "R8", "busy after reset", int'(busy), 0);
      check(done === 1'b0, "R8", "done after reset", int'(done), 0);

      // R4 sweep: every word written once
      for (int a = 0; a < 128; a++) full_write(a, pat(a));
      for (int a = 0; a < 128; a++) begin
         read_word(a, v);
         check(v === model[a], "R4", "sweep readback", int'(v), int'(model[a]));
      end

      // R5 commits during busy are ignored
      commit(10, 8'hC3);
      n = 1;
      @(negedge clk); n++;
      commit_req = 1'b1; commit_addr = 7'd20; commit_data = 8'h5A;
      @(negedge clk); n++;
      commit_addr = 7'd21; commit_data = 8'hA5;
      @(negedge clk); n++;
      commit_req = 1'b0;
      forever begin
         @(negedge clk);
         if (busy !== 1'b1 || n > TWR + 2) break;
         n++;
      end
      check(n == TWR, "R5", "no timer restart", n, TWR);
      model[10] = 8'hC3;
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R5", "no second cycle", int'(busy), 0);
      read_word(20, v);
      check(v === model[20], "R5", "ignored addr 20", int'(v), int'(model[20]));
      read_word(21, v);
      check(v === model[21], "R5", "ignored addr 21", int'(v), int'(model[21]));
      read_word(10, v);
      check(v === 8'hC3, "R4", "accepted word", int'(v), 8'hC3);

      // R8 reset aborts an update
      commit(30, 8'h77);
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(busy === 1'b0, "R8", "busy cleared", int'(busy), 0);
      read_word(30, v);
      check(v === 8'hFF, "R8", "aborted word stays erased", int'(v), 8'hFF);
      model[30] = 8'hFF;
      for (int k = 0; k < TWR + 2; k++) begin
         @(negedge clk);
         check(busy === 1'b0 && done === 1'b0, "R8", "no activity after abort",
               int'({busy, done}), 0);
      end
      for (int a = 0; a < 128; a++) begin
         read_word(a, v);
         check(v === model[a], "R8", "contents kept over reset", int'(v), int'(model[a]));
      end

      // recovery and back-to-back updates
      full_write(30, 8'h77);
      full_write(127, 8'h00);
      full_write(0, 8'hFF);
      for (int a = 0; a < 128; a++) begin
         read_word(a, v);
         check(v === model[a], "R4", "final readback", int'(v), int'(model[a]));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule